// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management interface found on Ethernet PHYs. It acts as the master and produces Clause 22 frames. Software sees two 32-bit words on a small register port. A command word sits at offset 0x0 and a configuration word at offset 0x4. To start a transfer, software writes one command word. That word holds the transfer kind, the target PHY, the register inside that PHY, the data for a write, and a start flag. The block then produces the management clock from its own divider, shifts the frame out, and takes read data back from the line.

While a frame is in flight, the start flag stays high and acts as the busy indication. When the frame ends, the flag drops. The low half of the command word then holds the value that was read. A separate flag records a PHY that failed to pull the line low during turnaround. Through the configuration word, software can set the divider and can drop the 32-bit preamble for PHYs that accept short frames.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the command word reads 0 and the configuration word reads 0x00000041 (Clause 22 select = 1, divider = 4, preamble skip = 0). MDC is low and MDIO is not driven (output enable 0).
- R2: A write to offset 0x0 with bit 29 set, made while idle, starts a frame. Bit 29 reads 1 from the next cycle on and returns to 0 exactly 2·N·(div+1) clock cycles after the write edge. N is 64 with preamble and 32 without it.
- R3: Bits leave MSB first, sampled on MDC rising edges, in this order: 32 ones (left out when configuration bit 12 is 1), start pattern 01, opcode from command bits 27:26 (10 = read, 01 = write), PHY address from bits 25:21, register address from bits 20:16, two turnaround bits, then 16 data bits.
- R4: MDC runs at the clock rate divided by 2·(div+1), where div is configuration bits 9:4. MDC is low whenever no frame is in flight.
- R5: On a write, the master drives turnaround as 1 then 0, followed by command bits 15:0. After completion, bits 15:0 still read the write data and bit 28 reads 0.
- R6: On a read, MDIO is released (output enable 0) for both turnaround bits and all 16 data bits. The data bits are sampled on MDC rising edges, and after completion command bits 15:0 return the value sampled.
- R7: Command bit 28 is set at the end of a read when MDIO was high at the rising edge of the second turnaround bit. It is 0 from the cycle after a new frame starts.
- R8: Writes to the command word while bit 29 is 1 have no effect. They do not change the opcode, addresses or data of the frame in flight, and they start nothing.
- R9: MDIO changes only with MDC falling edges while driven. It is released when no frame is in flight.
- R10: Configuration bits 0, 9:4 and 12 read back what was written. All other configuration bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the word at bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The bench plays the PHY. It records every bit at MDC rising edges and feeds read data and turnaround back on falling edges. Each captured frame is compared with one rebuilt from the command fields, and the busy time is checked against the divider, with and without preamble. The divider is exercised at both 0 and 63: an off-by-one there would stretch or shrink every bit and break the exact busy count. A controller that sampled on the wrong edge, or released the line one bit late, would show up as shifted read data or a driven turnaround. A missing fail flag, or one that persists into the next frame, shows up because a failed read is followed at once by a new start. A command write made mid-frame would, if accepted, corrupt the addresses read back afterwards.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter logic [5:0] DIV_RESET = 6'd4,
  parameter int         PRE_LEN   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam logic [PW-1:0] PRE_FULL = PW'(PRE_LEN);

  logic          busy, fail, c22, nopre, mdc_q;
  logic [1:0]    op;
  logic [4:0]    phy, rad, fidx;
  logic [15:0]   dat;
  logic [5:0]    div, cnt;
  logic [PW-1:0] pre;
  logic [31:0]   sh;

  wire cmd_sel = (bus_addr == 4'h0);
  wire cfg_sel = (bus_addr == 4'h4);
  wire launch  = bus_we & cmd_sel & ~busy & bus_wdata[29];
  wire tick    = busy & (cnt >= div);
  wire is_rd   = (op == 2'b10);
  wire in_pre  = (pre != '0);
  wire w_rd    = (bus_wdata[27:26] == 2'b10);

  assign mdc       = mdc_q;
  assign mdio_oe   = busy & (in_pre | ~is_rd | (fidx < 5'd14));
  assign mdio_o    = mdio_oe & (in_pre | sh[31]);
  assign bus_rdata = cmd_sel ? {2'b00, busy, fail, op, phy, rad, dat} :
                     cfg_sel ? {19'd0, nopre, 2'b00, div, 3'b000, c22} : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c22   <= 1'b1;
      div   <= DIV_RESET;
      nopre <= 1'b0;
    end else if (bus_we & cfg_sel) begin
      c22   <= bus_wdata[0];
      div   <= bus_wdata[9:4];
      nopre <= bus_wdata[12];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fail  <= 1'b0;
      op    <= '0;
      phy   <= '0;
      rad   <= '0;
      dat   <= '0;
      cnt   <= '0;
      mdc_q <= 1'b0;
      pre   <= '0;
      fidx  <= '0;
      sh    <= '0;
    end else if (!busy) begin
      if (bus_we & cmd_sel) begin
        op  <= bus_wdata[27:26];
        phy <= bus_wdata[25:21];
        rad <= bus_wdata[20:16];
        dat <= bus_wdata[15:0];
      end
      if (launch) begin
        busy  <= 1'b1;
        fail  <= 1'b0;
        cnt   <= '0;
        mdc_q <= 1'b0;
        fidx  <= '0;
        pre   <= nopre ? '0 : PRE_FULL;
        sh    <= {2'b01, bus_wdata[27:16], (w_rd ? 2'b11 : 2'b10), bus_wdata[15:0]};
      end
    end else if (tick) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
      if (mdc_q) begin
        if (in_pre) pre <= pre - 1'b1;
        else if (fidx == 5'd31) begin
          busy <= 1'b0;
        end else begin
          fidx <= fidx + 1'b1;
          sh   <= {sh[30:0], 1'b0};
        end
      end else if (!in_pre && is_rd) begin
        if (fidx == 5'd15) fail <= mdio_i;
        if (fidx >= 5'd16) dat <= {dat[14:0], mdio_i};
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_idle_mdc_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc_q);

  p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && !mdc_q && bus_rdata[29] | !cmd_sel));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && cmd_sel) |=> ($stable(op) && $stable(phy) && $stable(rad)));

  p_fail_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !fail);

  p_mdio_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o)))
      |-> $fell(mdc_q));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_mgmt_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic cap_o [0:63];
  logic cap_oe[0:63];
  int   rc = 0;
  time  t0 = 0, t1 = 0;
  bit   t_rd = 0, t_ta = 1;
  int   t_pre = 32;
  logic [15:0] t_resp = 16'h0;

  always @(posedge mdc) begin
    if (rc < 64) begin
      cap_o[rc]  = mdio_o;
      cap_oe[rc] = mdio_oe;
    end
    if (rc == 0) t0 = $time;
    if (rc == 1) t1 = $time;
    rc = rc + 1;
  end

  always @(negedge mdc) begin
    int f;
    f = rc - t_pre;
    if (t_rd && f == 15) mdio_i = t_ta ? 1'b0 : 1'b1;
    else if (t_rd && f >= 16 && f <= 31) mdio_i = t_resp[31-f];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] frame_word(input logic [1:0] op, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
    return {2'b01, op, p, r, 2'b10, d};
  endfunction

  function automatic int exp_cycles(input logic [5:0] dv, input bit np);
    return 2 * (np ? 32 : 64) * (int'(dv) + 1);
  endfunction

  task automatic run_txn(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input logic [5:0] dv, input bit np,
                         input bit ta_ok, input logic [15:0] resp, input bit inject);
    logic [31:0] rd, fw;
    int cyc, nb;
    bit bad_pre, bad_hdr, bad_tail;
    bus_write(4'h4, {19'd0, np, 2'b00, dv, 3'b000, 1'b1});
    rc = 0; t_rd = (op == 2'b10); t_ta = ta_ok; t_resp = resp;
    t_pre = np ? 0 : 32; mdio_i = 1'b1;
    bus_write(4'h0, {2'b00, 1'b1, 1'b0, op, p, r, d});
    bus_read(4'h0, rd);
    chk(rd[28] == 1'b0, "R7 fail flag clear at start", {31'd0, rd[28]}, 32'd0);
    cyc = 0;
    forever begin
      bus_read(4'h0, rd);
      if (!rd[29] || cyc > 20000) break;
      cyc++;
      if (inject && cyc == 7) begin
        bus_wdata = {2'b00, 1'b1, 1'b0, ~op, ~p, ~r, ~d};
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    nb = np ? 32 : 64;
    chk(cyc == exp_cycles(dv, np), "R2 busy duration", cyc, exp_cycles(dv, np));
    chk(rc == nb, "R3 MDC rising edge count", rc, nb);
    chk((t1 - t0) == time'(16 * (int'(dv) + 1)), "R4 MDC period",
        32'(t1 - t0), 32'(16 * (int'(dv) + 1)));
    fw = frame_word(op, p, r, d);
    bad_pre = 0; bad_hdr = 0; bad_tail = 0;
    for (int i = 0; i < t_pre; i++)
      if (cap_o[i] !== 1'b1 || cap_oe[i] !== 1'b1) bad_pre = 1;
    for (int i = 0; i < 14; i++)
      if (cap_o[t_pre+i] !== fw[31-i] || cap_oe[t_pre+i] !== 1'b1) bad_hdr = 1;
    for (int i = 14; i < 32; i++) begin
      if (t_rd) begin
        if (cap_oe[t_pre+i] !== 1'b0) bad_tail = 1;
      end else if (cap_o[t_pre+i] !== fw[31-i] || cap_oe[t_pre+i] !== 1'b1) bad_tail = 1;
    end
    chk(!bad_pre, "R3 preamble bits", {31'd0, bad_pre}, 32'd0);
    chk(!bad_hdr, "R3 start/op/addr bits", {31'd0, bad_hdr}, 32'd0);
    bus_read(4'h0, rd);
    if (t_rd) begin
      chk(!bad_tail, "R6 line released for TA and data", {31'd0, bad_tail}, 32'd0);
      chk(rd[15:0] == resp, "R6 read data", {16'd0, rd[15:0]}, {16'd0, resp});
      chk(rd[28] == !ta_ok, "R7 read fail flag", {31'd0, rd[28]}, {31'd0, !ta_ok});
    end else begin
      chk(!bad_tail, "R5 TA and data driven", {31'd0, bad_tail}, 32'd0);
      chk(rd[15:0] == d && rd[28] == 1'b0, "R5 write data kept, no fail",
          {15'd0, rd[28], rd[15:0]}, {16'd0, d});
    end
    if (inject)
      chk(rd[27:16] == {op, p, r}, "R8 command write while busy ignored",
          {20'd0, rd[27:16]}, {20'd0, op, p, r});
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle: MDC low, line released",
        {30'd0, mdc, mdio_oe}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int sd;
    sd = $urandom(32'd2718);
    #20;
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(4'h0, rd);
    chk(rd == 32'd0, "R1 command reset value", rd, 32'd0);
    bus_read(4'h4, rd);
    chk(rd == 32'h41, "R1 config reset value", rd, 32'h41);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {30'd0, mdc, mdio_oe}, 32'd0);

    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, rd);
    chk(rd == 32'h0000_13F1, "R10 config readback all ones", rd, 32'h13F1);
    bus_write(4'h4, 32'h0000_0020);
    bus_read(4'h4, rd);
    chk(rd == 32'h20, "R10 config readback divider only", rd, 32'h20);

    bus_write(4'h0, 32'h0000_1234);
    bus_read(4'h0, rd);
    chk(rd[29] == 1'b0 && mdc == 1'b0, "R2 no start without bit 29", rd, 32'h0);

    run_txn(2'b01, 5'h1F, 5'h00, 16'hA5C3, 6'd0, 1'b0, 1'b1, 16'h0, 1'b0);
    run_txn(2'b10, 5'h03, 5'h01, 16'h0000, 6'd1, 1'b0, 1'b1, 16'h796D, 1'b0);
    run_txn(2'b10, 5'h11, 5'h1E, 16'h0000, 6'd2, 1'b1, 1'b0, 16'hFFFF, 1'b0);
    run_txn(2'b10, 5'h04, 5'h02, 16'h0000, 6'd0, 1'b1, 1'b1, 16'h0001, 1'b1);
    run_txn(2'b01, 5'h00, 5'h1F, 16'h8000, 6'd63, 1'b1, 1'b1, 16'h0, 1'b1);

    for (int k = 0; k < 24; k++) begin
      logic [1:0] op;
      op = ($urandom % 2 == 0) ? 2'b10 : 2'b01;
      run_txn(op, 5'($urandom), 5'($urandom), 16'($urandom), 6'($urandom % 8),
              1'($urandom), ($urandom % 4) != 0, 16'($urandom), ($urandom % 3) == 0);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule